// File: doc/BRIEF.md
# Banked PCS Register Window

This block is the register file of a physical coding sublayer, seen by software through a 16-bit host bus that covers an 8 KiB window. The window is indirect. One fixed offset, 0x1FE, always reaches a bank-select register. Every other even offset is halved to give a register index inside whichever of four banks that select register currently names. The four banks are control, MII standard, timing and vendor MII. Each bank has its own size, and the block range-checks every index against it. Bad reads return zero and bad writes are dropped, so a misprogrammed driver cannot corrupt state.

The block models no serdes, autonegotiation or PLL behaviour. Status words are ordinary storage that starts at a fixed reset value. All four banks reload those values in two cases: on hardware reset, and when software writes the MII control word with its top bit set. The software reload leaves the bank-select register alone, so the driver stays in the bank it had selected.

Reads are answered one cycle after the request through a registered response port. Writes take effect at the clock edge of the request cycle.

Top module: `pcs_regwin`

## Requirements
- R1: A read request (`req_vld`=1, `req_wr`=0) produces `rsp_vld`=1 with the read word on `rsp_rdata` in the following cycle. `rsp_vld` is 0 after any cycle with no read request, including cycles with writes.
- R2: Offset 0x1FE reads and writes the 16-bit bank-select register, whatever value it holds.
- R3: The bank-select values map to banks as follows: 0x1F00 selects the MII bank (16 words), 0x1E00 the control bank (9 words), 0x1F80 the vendor bank (227 words) and 0x1F07 the timing bank (17 words). Register index = offset / 2. A word written at a valid index reads back unchanged.
- R4: An index at or above the selected bank's size reads as 0, and a write to it changes no register.
- R5: While the bank-select register holds any value other than the four in R3, reads of non-0x1FE offsets return 0 and writes to them change no register.
- R6: An access at an odd offset (including 0x1FF) is rejected: a read returns 0 and a write changes neither banks nor the bank-select register.
- R7: Hardware reset (`rst_n`=0) clears the bank-select register to 0 and loads every bank word with its reset value. The nonzero reset values, given as bank[index]=value, are: MII[0]=0x1140, MII[1]=0x0109, MII[2]=0x699E, MII[3]=0xCED0, MII[4]=0x0020, MII[15]=0xC000; control[4]=0x699E, control[8]=0x8000; timing[8]=0x0003, timing[9]=0x0038, timing[11]=0x0038, timing[13]=0x0058, timing[15]=0x0048; vendor[0]=0x2400, vendor[2]=0x000A, vendor[6]=0x899C, vendor[16]=0x0010, vendor[56]=0x000A, vendor[58]=0x007F, vendor[61]=0x0001, vendor[88]=0x0100, vendor[89]=0x1100, vendor[93]=0x000E, vendor[120]=0x0100, vendor[121]=0x0032, vendor[136]=0x0001, vendor[152]=0x0019. Every other word resets to 0.
- R8: A write to MII index 0 with data bit 15 set reloads all four banks with their R7 values at that clock edge and discards the written data. MII control then reads 0x1140, so the reset bit reads back as 0.
- R9: The software reload of R8 leaves the bank-select register unchanged. A write to MII index 0 with bit 15 clear is an ordinary store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| req_vld | input | 1 | Host access request this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte offset inside the 8 KiB window |
| req_wdata | input | 16 | Write data |
| rsp_vld | output | 1 | Read data valid (one cycle after a read request) |
| rsp_rdata | output | 16 | Read data |

## Verification
The assertions check the behaviour of the bank-select register and the response timing on every cycle. They cover the one-cycle read answer with no stray strobe, zero data for odd offsets and for an undefined bank select, and read-back of the select register. They also check that the select register changes only through a direct write at 0x1FE, which covers its survival across a software reload. Only the bench scenarios can show the bank contents. These are the reset image of every word, the read-back of written patterns in all four banks, the dropping of out-of-range and rejected writes, and the full reload after a reset command followed by continued access in the same bank.

// File: rtl/pcs_regwin_pkg.sv
package pcs_regwin_pkg;

    localparam int ADDR_W = 13;            // 8 KiB byte window
    localparam int DATA_W = 16;
    localparam int IDX_W  = ADDR_W - 1;    // word index width
    localparam int N_BANK = 4;

    localparam logic [ADDR_W-1:0] SEL_OFS = 13'h1FE;

    localparam logic [DATA_W-1:0] SEL_CTL = 16'h1E00;
    localparam logic [DATA_W-1:0] SEL_MII = 16'h1F00;
    localparam logic [DATA_W-1:0] SEL_TIM = 16'h1F07;
    localparam logic [DATA_W-1:0] SEL_VND = 16'h1F80;

    localparam int SWRST_BIT = 15;

    typedef enum logic [1:0] {
        BK_CTL = 2'd0,
        BK_MII = 2'd1,
        BK_TIM = 2'd2,
        BK_VND = 2'd3
    } bank_e;

    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,   // no request
        ACC_SEL  = 2'd1,   // bank-select register
        ACC_BANK = 2'd2,   // in-range bank word
        ACC_DROP = 2'd3    // rejected access
    } acc_e;

    typedef enum logic {
        RSP_IDLE = 1'b0,
        RSP_DATA = 1'b1
    } rsp_state_e;

    // Reset image of each bank word.
    function automatic logic [DATA_W-1:0] reset_word(bank_e b, int idx);
        logic [DATA_W-1:0] v;
        v = '0;
        unique case (b)
            BK_CTL: begin
                case (idx)
                    4:       v = 16'h699E;
                    8:       v = 16'h8000;
                    default: v = '0;
                endcase
            end
            BK_MII: begin
                case (idx)
                    0:       v = 16'h1140;
                    1:       v = 16'h0109;
                    2:       v = 16'h699E;
                    3:       v = 16'hCED0;
                    4:       v = 16'h0020;
                    15:      v = 16'hC000;
                    default: v = '0;
                endcase
            end
            BK_TIM: begin
                case (idx)
                    8:       v = 16'h0003;
                    9:       v = 16'h0038;
                    11:      v = 16'h0038;
                    13:      v = 16'h0058;
                    15:      v = 16'h0048;
                    default: v = '0;
                endcase
            end
            BK_VND: begin
                case (idx)
                    0:       v = 16'h2400;
                    2:       v = 16'h000A;
                    6:       v = 16'h899C;
                    16:      v = 16'h0010;
                    56:      v = 16'h000A;
                    58:      v = 16'h007F;
                    61:      v = 16'h0001;
                    88:      v = 16'h0100;
                    89:      v = 16'h1100;
                    93:      v = 16'h000E;
                    120:     v = 16'h0100;
                    121:     v = 16'h0032;
                    136:     v = 16'h0001;
                    152:     v = 16'h0019;
                    default: v = '0;
                endcase
            end
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pcs_regwin_decode.sv
module pcs_regwin_decode
    import pcs_regwin_pkg::*;
#(
    parameter int CTL_N = 9,
    parameter int MII_N = 16,
    parameter int TIM_N = 17,
    parameter int VND_N = 227
) (
    input  logic              req_vld,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] sel_q,
    output acc_e              acc,
    output bank_e             bank,
    output logic [IDX_W-1:0]  idx
);

    logic hit;
    int   depth;

    // Bank lookup from the select register.
    always_comb begin
        bank  = BK_CTL;
        hit   = 1'b0;
        depth = 0;
        case (sel_q)
            SEL_CTL: begin bank = BK_CTL; hit = 1'b1; depth = CTL_N; end
            SEL_MII: begin bank = BK_MII; hit = 1'b1; depth = MII_N; end
            SEL_TIM: begin bank = BK_TIM; hit = 1'b1; depth = TIM_N; end
            SEL_VND: begin bank = BK_VND; hit = 1'b1; depth = VND_N; end
            default: begin bank = BK_CTL; hit = 1'b0; depth = 0;     end
        endcase
    end

    assign idx = req_addr[ADDR_W-1:1];

    // Access classification; priority: idle, odd, select, bank range.
    always_comb begin
        if (!req_vld) begin
            acc = ACC_IDLE;
        end else if (req_addr[0]) begin
            acc = ACC_DROP;
        end else if (req_addr == SEL_OFS) begin
            acc = ACC_SEL;
        end else if (hit && (int'(idx) < depth)) begin
            acc = ACC_BANK;
        end else begin
            acc = ACC_DROP;
        end
    end

endmodule

// File: rtl/pcs_regwin_bank.sv
module pcs_regwin_bank
    import pcs_regwin_pkg::*;
#(
    parameter bank_e BANK  = BK_CTL,
    parameter int    DEPTH = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] words [DEPTH];

    // Storage: reload has priority over the store it arrives with.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= reset_word(BANK, i);
            end
        end else if (reload) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= reset_word(BANK, i);
            end
        end else if (wr_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (int'(idx) == i) begin
                    words[i] <= wdata;
                end
            end
        end
    end

    // Read selection; an index outside the bank yields zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(idx) == i) begin
                rd_data = words[i];
            end
        end
    end

endmodule

// File: rtl/pcs_regwin.sv
module pcs_regwin
    import pcs_regwin_pkg::*;
#(
    parameter int CTL_N = 9,
    parameter int MII_N = 16,
    parameter int TIM_N = 17,
    parameter int VND_N = 227
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_vld,
    input  logic        req_wr,
    input  logic [12:0] req_addr,
    input  logic [15:0] req_wdata,
    output logic        rsp_vld,
    output logic [15:0] rsp_rdata
);

    localparam int DEPTHS [N_BANK] = '{CTL_N, MII_N, TIM_N, VND_N};

    logic [DATA_W-1:0] sel_q;
    acc_e              acc;
    bank_e             dec_bank;
    logic [IDX_W-1:0]  dec_idx;
    logic [DATA_W-1:0] bank_rd [N_BANK];
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rdata_q;
    logic              is_read;
    logic              is_write;
    logic              sel_wr;
    logic              bank_wr;
    logic              reload;
    rsp_state_e        rsp_state;
    rsp_state_e        rsp_next;

    assign is_read  = req_vld && !req_wr;
    assign is_write = req_vld &&  req_wr;

    pcs_regwin_decode #(
        .CTL_N(CTL_N),
        .MII_N(MII_N),
        .TIM_N(TIM_N),
        .VND_N(VND_N)
    ) u_decode (
        .req_vld (req_vld),
        .req_addr(req_addr),
        .sel_q   (sel_q),
        .acc     (acc),
        .bank    (dec_bank),
        .idx     (dec_idx)
    );

    // Write steering.
    always_comb begin
        sel_wr  = 1'b0;
        bank_wr = 1'b0;
        unique case (acc)
            ACC_IDLE: ;
            ACC_SEL:  sel_wr  = is_write;
            ACC_BANK: bank_wr = is_write;
            ACC_DROP: ;
        endcase
    end

    assign reload = bank_wr && (dec_bank == BK_MII) &&
                    (dec_idx == '0) && req_wdata[SWRST_BIT];

    // Bank-select register: only a direct write changes it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (sel_wr) begin
            sel_q <= req_wdata;
        end
    end

    genvar g;
    for (g = 0; g < N_BANK; g++) begin : g_bank
        pcs_regwin_bank #(
            .BANK (bank_e'(g)),
            .DEPTH(DEPTHS[g])
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .reload (reload),
            .wr_en  (bank_wr && (dec_bank == bank_e'(g))),
            .idx    (dec_idx),
            .wdata  (req_wdata),
            .rd_data(bank_rd[g])
        );
    end

    // Read source selection.
    always_comb begin
        unique case (acc)
            ACC_IDLE: rd_word = '0;
            ACC_SEL:  rd_word = sel_q;
            ACC_BANK: rd_word = bank_rd[dec_bank];
            ACC_DROP: rd_word = '0;
        endcase
    end

    // Response state machine: next-state logic.
    always_comb begin
        unique case (rsp_state)
            RSP_IDLE: rsp_next = is_read ? RSP_DATA : RSP_IDLE;
            RSP_DATA: rsp_next = is_read ? RSP_DATA : RSP_IDLE;
        endcase
    end

    // Response state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_state <= RSP_IDLE;
        end else begin
            rsp_state <= rsp_next;
        end
    end

    // Read data capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (is_read) begin
            rdata_q <= rd_word;
        end
    end

    // Outputs.
    always_comb begin
        unique case (rsp_state)
            RSP_IDLE: begin
                rsp_vld   = 1'b0;
                rsp_rdata = '0;
            end
            RSP_DATA: begin
                rsp_vld   = 1'b1;
                rsp_rdata = rdata_q;
            end
        endcase
    end

endmodule

// File: rtl/pcs_regwin_chk.sv
module pcs_regwin_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_vld,
    input logic        req_wr,
    input logic [12:0] req_addr,
    input logic [15:0] req_wdata,
    input logic        rsp_vld,
    input logic [15:0] rsp_rdata,
    input logic [15:0] sel_q
);

    logic rd_req;
    logic sel_hit;
    logic sel_known;

    assign rd_req    = req_vld && !req_wr;
    assign sel_hit   = (req_addr == 13'h1FE);
    assign sel_known = (sel_q == 16'h1E00) || (sel_q == 16'h1F00) ||
                       (sel_q == 16'h1F07) || (sel_q == 16'h1F80);

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_vld) else $error("response missing");  // R1

    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_vld) else $error("stray response");  // R1

    AST_SEL_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && sel_hit) |=> (rsp_rdata == $past(sel_q))) else $error("select readback");  // R2

    AST_SEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_wr && sel_hit) |=> (sel_q == $past(req_wdata))) else $error("select write");  // R2

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_vld && req_wr && sel_hit) |=> $stable(sel_q)) else $error("select changed");  // R9

    AST_ODD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_addr[0]) |=> (rsp_rdata == 16'h0000)) else $error("odd read");  // R6

    AST_BAD_SEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !req_addr[0] && !sel_hit && !sel_known) |=> (rsp_rdata == 16'h0000)) else $error("bad select read");  // R5

endmodule

bind pcs_regwin pcs_regwin_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_vld  (req_vld),
    .req_wr   (req_wr),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rsp_vld  (rsp_vld),
    .rsp_rdata(rsp_rdata),
    .sel_q    (sel_q)
);

// File: tb/sim_pcs_regwin.sv
`timescale 1ns/1ps
module sim_pcs_regwin;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic        req_wr = 1'b0;
    logic [12:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_vld;
    logic [15:0] rsp_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam logic [15:0] SELV [4] = '{16'h1E00, 16'h1F00, 16'h1F07, 16'h1F80};
    localparam int          DEP  [4] = '{9, 16, 17, 227};

    always #5 clk = ~clk;

    pcs_regwin u0 (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_vld(rsp_vld), .rsp_rdata(rsp_rdata)
    );

    // Reset image taken from the requirement list (R7).
    function automatic logic [15:0] exp_reset(int b, int i);
        if (b == 1) begin
            if (i == 0)  return 16'h1140;
            if (i == 1)  return 16'h0109;
            if (i == 2)  return 16'h699E;
            if (i == 3)  return 16'hCED0;
            if (i == 4)  return 16'h0020;
            if (i == 15) return 16'hC000;
        end else if (b == 0) begin
            if (i == 4)  return 16'h699E;
            if (i == 8)  return 16'h8000;
        end else if (b == 2) begin
            if (i == 8)  return 16'h0003;
            if (i == 9 || i == 11) return 16'h0038;
            if (i == 13) return 16'h0058;
            if (i == 15) return 16'h0048;
        end else begin
            if (i == 0)   return 16'h2400;
            if (i == 2 || i == 56) return 16'h000A;
            if (i == 6)   return 16'h899C;
            if (i == 16)  return 16'h0010;
            if (i == 58)  return 16'h007F;
            if (i == 61 || i == 136) return 16'h0001;
            if (i == 88 || i == 120) return 16'h0100;
            if (i == 89)  return 16'h1100;
            if (i == 93)  return 16'h000E;
            if (i == 121) return 16'h0032;
            if (i == 152) return 16'h0019;
        end
        return 16'h0000;
    endfunction

    function automatic logic [15:0] pat(int b, int i);
        return 16'((b * 16'h1111 + i * 7 + 16'h0300)) & 16'h7FFF;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [12:0] a, input logic [15:0] d);
        @(negedge clk);
        req_vld = 1'b1; req_wr = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_vld = 1'b0; req_wr = 1'b0;
        chk("R1 no response after write", {15'd0, rsp_vld}, 16'd0);
    endtask

    task automatic do_read(input logic [12:0] a, output logic [15:0] d);
        @(negedge clk);
        req_vld = 1'b1; req_wr = 1'b0; req_addr = a;
        @(negedge clk);
        req_vld = 1'b0;
        d = rsp_rdata;
        chk("R1 response strobe", {15'd0, rsp_vld}, 16'd1);
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        apply_reset();
        chk("R1 idle strobe after reset", {15'd0, rsp_vld}, 16'd0);
        do_read(13'h1FE, d);
        chk("R7 select cleared by reset", d, 16'h0000);

        // R7 / R4: reset image and range of every bank
        for (int b = 0; b < 4; b++) begin
            do_write(13'h1FE, SELV[b]);
            do_read(13'h1FE, d);
            chk("R2 select readback", d, SELV[b]);
            for (int i = 0; i < DEP[b] + 2; i++) begin
                do_read(13'(2 * i), d);
                if (i < DEP[b]) chk("R7 reset value", d, exp_reset(b, i));
                else            chk("R4 out-of-range read", d, 16'h0000);
            end
        end

        // R3 / R4 / R9: pattern store, read back, out-of-range writes dropped
        for (int b = 0; b < 4; b++) begin
            do_write(13'h1FE, SELV[b]);
            for (int i = 0; i < DEP[b] + 2; i++) do_write(13'(2 * i), pat(b, i));
            for (int i = 0; i < DEP[b] + 2; i++) begin
                do_read(13'(2 * i), d);
                if (i < DEP[b]) chk("R3 stored word", d, pat(b, i));
                else            chk("R4 dropped write", d, 16'h0000);
            end
        end
        do_write(13'h1FE, SELV[1]);
        do_read(13'h0000, d);
        chk("R9 plain store to MII control", d, pat(1, 0));

        // R5: undefined select values
        begin
            logic [15:0] bad [5] = '{16'h0000, 16'h1E01, 16'h1F01, 16'h1F08, 16'hFFFF};
            for (int k = 0; k < 5; k++) begin
                do_write(13'h1FE, bad[k]);
                for (int i = 0; i < 9; i++) do_write(13'(2 * i), 16'hFFFF);
                for (int i = 0; i < 9; i++) begin
                    do_read(13'(2 * i), d);
                    chk("R5 undefined select read", d, 16'h0000);
                end
                do_read(13'h1FE, d);
                chk("R2 undefined select readback", d, bad[k]);
            end
            for (int b = 0; b < 4; b++) begin
                do_write(13'h1FE, SELV[b]);
                for (int i = 0; i < 9; i++) begin
                    do_read(13'(2 * i), d);
                    chk("R5 bank untouched", d, pat(b, i));
                end
            end
        end

        // R6: odd offsets
        do_write(13'h1FE, SELV[1]);
        do_write(13'h0003, 16'hAAAA);
        do_read(13'h0003, d);
        chk("R6 odd read zero", d, 16'h0000);
        do_read(13'h0002, d);
        chk("R6 odd write dropped", d, pat(1, 1));
        do_write(13'h1FF, 16'h1234);
        do_read(13'h1FF, d);
        chk("R6 odd select read zero", d, 16'h0000);
        do_read(13'h1FE, d);
        chk("R6 select untouched by odd write", d, SELV[1]);

        // R8 / R9: software reload
        do_write(13'h0000, 16'h8042);
        do_read(13'h1FE, d);
        chk("R9 select kept over reload", d, SELV[1]);
        do_read(13'h0000, d);
        chk("R8 reset bit reads zero", d, 16'h1140);
        for (int b = 0; b < 4; b++) begin
            do_write(13'h1FE, SELV[b]);
            for (int i = 0; i < DEP[b]; i++) begin
                do_read(13'(2 * i), d);
                chk("R8 reload value", d, exp_reset(b, i));
            end
        end

        // R7: hardware reset after changes
        do_write(13'h1FE, SELV[3]);
        do_write(13'h0010, 16'h5555);
        apply_reset();
        do_read(13'h1FE, d);
        chk("R7 select cleared by reset", d, 16'h0000);
        do_write(13'h1FE, SELV[3]);
        do_read(13'h0010, d);
        chk("R7 vendor word reset", d, exp_reset(3, 8));
        do_read(13'h0020, d);
        chk("R7 vendor status reset", d, 16'h0010);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule